// File: doc/BRIEF.md
# Direct-address load/store bus sequencer

This block is a small bus master that runs a two-instruction program stream over a byte-wide memory bus with a 16-bit address. One instruction copies the accumulator to a 16-bit address, and the other copies the byte at a 16-bit address into the accumulator. Each instruction takes three bytes in program memory: the opcode first, then the operand address with its low byte ahead of its high byte. An input/output port decoded on the full address bus sees the final data transfer as an ordinary memory access. This lets a peripheral be reached with the same instructions that reach memory.

Every instruction runs as four machine cycles of three clocks each. The first three cycles fetch the instruction bytes from the program counter. The fourth cycle reads or writes the data byte at the assembled operand address. The opcode picks the direction and the strobe of that last cycle. Any other opcode is consumed in one fetch cycle and has no further effect. The accumulator is brought out as a port so that the result of a load can be seen.

Top module: `dirxfer_seq`

## Requirements
- R1: While reset is held low, the address bus reads 0000h, MREQ, RD and WR (all active low) are high, the data output enable is low and the accumulator reads 00h. The first machine cycle after release fetches from 0000h.
- R2: Every machine cycle lasts three clocks. In the first clock all strobes are high and the address is already valid. In the second and third clocks MREQ is low together with exactly one of RD or WR.
- R3: The opcode and operand fetch cycles are reads at consecutive program-counter values. The program counter advances by one after each fetch cycle.
- R4: The operand address is assembled little-endian. The byte fetched second is address bits 7:0 and the byte fetched third is address bits 15:8.
- R5: Opcode 32h (store) ends with a write cycle at the operand address. WR is low, RD is high and the accumulator value is on the data output.
- R6: Opcode 3Ah (load) ends with a read cycle at the operand address. The byte present at the end of its third clock is written to the accumulator and is visible from the next machine cycle.
- R7: Any opcode other than 32h or 3Ah uses one fetch cycle only. The next opcode is fetched at the following address and the accumulator is unchanged.
- R8: The data output enable is high for all three clocks of a store's write cycle and low in every other clock.
- R9: RD and WR are never low together, and neither is low while MREQ is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Read data from memory or a mapped input port |
| addr_o | output | 16 | Address bus |
| data_o | output | 8 | Write data (accumulator) |
| data_oe_o | output | 1 | Data bus output enable, high during store writes |
| mreq_n_o | output | 1 | Memory request strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| acc_o | output | 8 | Current accumulator value |

## Verification
A wrong phase counter moves or lengthens the strobe pulses, and this shows within one machine cycle. A skipped or doubled program-counter step shows in the very next fetch address. A swapped operand assembly or a wrong opcode decode shows only in the fourth machine cycle. There the address, the strobe choice and the output enable are wrong at once, three clocks after the last fetch. A load that samples at the wrong moment or writes the accumulator wrongly shows on the accumulator port at the start of the following machine cycle. A store that then reads the accumulator out exposes it again.

// File: rtl/dirxfer_pkg.sv
package dirxfer_pkg;

    // Bus widths: the operand address is built from two data bytes.
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    // Clock phase inside one machine cycle.
    typedef enum logic [1:0] {
        TS_ADDR = 2'd0,   // address valid, strobes idle
        TS_STRB = 2'd1,   // strobes asserted
        TS_LAST = 2'd2    // strobes held, read data sampled at the closing edge
    } tstate_e;

    // Machine cycle within one instruction.
    typedef enum logic [1:0] {
        MC_OPC  = 2'd0,   // opcode fetch
        MC_OPLO = 2'd1,   // operand low byte fetch
        MC_OPHI = 2'd2,   // operand high byte fetch
        MC_XFER = 2'd3    // data transfer at the operand address
    } mcyc_e;

    typedef struct packed {
        mcyc_e          mc;
        logic [AW-1:0]  pc;
        logic [DW-1:0]  opc;
        logic [AW-1:0]  oper;
        logic [DW-1:0]  acc;
    } core_state_t;

endpackage

// File: rtl/dirxfer_tphase.sv
module dirxfer_tphase
    import dirxfer_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    output tstate_e tstate_o,
    output logic    last_o
);

    tstate_e ts_d, ts_q;

    always_comb begin
        case (ts_q)
            TS_ADDR: ts_d = TS_STRB;
            TS_STRB: ts_d = TS_LAST;
            default: ts_d = TS_ADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= TS_ADDR;
        else        ts_q <= ts_d;
    end

    assign tstate_o = ts_q;
    assign last_o   = (ts_q == TS_LAST);

endmodule

// File: rtl/dirxfer_core.sv
module dirxfer_core
    import dirxfer_pkg::*;
#(
    parameter logic [DW-1:0] OPC_STORE = 8'h32,
    parameter logic [DW-1:0] OPC_LOAD  = 8'h3A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last_i,
    input  logic [DW-1:0] data_i,
    output mcyc_e         mc_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] oper_o,
    output logic [DW-1:0] acc_o,
    output logic          is_store_o
);

    localparam logic [AW-1:0] PC_STEP = AW'(1);

    core_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (last_i) begin
            case (s_q.mc)
                MC_OPC: begin
                    s_d.opc = data_i;
                    s_d.pc  = s_q.pc + PC_STEP;
                    if (data_i == OPC_STORE || data_i == OPC_LOAD)
                        s_d.mc = MC_OPLO;
                end
                MC_OPLO: begin
                    s_d.oper[DW-1:0] = data_i;
                    s_d.pc           = s_q.pc + PC_STEP;
                    s_d.mc           = MC_OPHI;
                end
                MC_OPHI: begin
                    s_d.oper[AW-1:DW] = data_i;
                    s_d.pc            = s_q.pc + PC_STEP;
                    s_d.mc            = MC_XFER;
                end
                default: begin
                    if (s_q.opc == OPC_LOAD)
                        s_d.acc = data_i;
                    s_d.mc = MC_OPC;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mc: MC_OPC, pc: '0, opc: '0, oper: '0, acc: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mc_o       = s_q.mc;
    assign pc_o       = s_q.pc;
    assign oper_o     = s_q.oper;
    assign acc_o      = s_q.acc;
    assign is_store_o = (s_q.opc == OPC_STORE);

    // R3: every completed fetch cycle moves the program counter by exactly one.
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && s_q.mc != MC_XFER) |=> (s_q.pc == $past(s_q.pc) + PC_STEP));

    // R3: the program counter holds still while a transfer cycle runs.
    p_pc_hold_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mc == MC_XFER) |=> $stable(s_q.pc));

    // R7: the accumulator changes only at the close of a load transfer.
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_i && s_q.mc == MC_XFER && s_q.opc == OPC_LOAD) |=> $stable(s_q.acc));

    // R5: a transfer cycle is always followed by a new opcode fetch.
    p_xfer_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && s_q.mc == MC_XFER) |=> (s_q.mc == MC_OPC));

endmodule

// File: rtl/dirxfer_bus.sv
module dirxfer_bus
    import dirxfer_pkg::*;
(
    input  mcyc_e         mc_i,
    input  tstate_e       tstate_i,
    input  logic          is_store_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] oper_i,
    input  logic [DW-1:0] acc_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          mreq_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o
);

    logic xfer_cyc;
    logic wr_cyc;
    logic strobe_on;

    always_comb begin
        xfer_cyc  = (mc_i == MC_XFER);
        wr_cyc    = xfer_cyc && is_store_i;
        strobe_on = (tstate_i != TS_ADDR);

        addr_o    = xfer_cyc ? oper_i : pc_i;
        data_o    = acc_i;
        data_oe_o = wr_cyc;
        mreq_n_o  = !strobe_on;
        rd_n_o    = !(strobe_on && !wr_cyc);
        wr_n_o    = !(strobe_on && wr_cyc);
    end

endmodule

// File: rtl/dirxfer_seq.sv
module dirxfer_seq
    import dirxfer_pkg::*;
#(
    parameter logic [DW-1:0] OPC_STORE = 8'h32,
    parameter logic [DW-1:0] OPC_LOAD  = 8'h3A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          mreq_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [DW-1:0] acc_o
);

    tstate_e       tstate;
    logic          last_clk;
    mcyc_e         mc;
    logic [AW-1:0] pc;
    logic [AW-1:0] oper;
    logic [DW-1:0] acc;
    logic          is_store;

    dirxfer_tphase u_tphase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tstate_o (tstate),
        .last_o   (last_clk)
    );

    dirxfer_core #(
        .OPC_STORE (OPC_STORE),
        .OPC_LOAD  (OPC_LOAD)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_i     (last_clk),
        .data_i     (data_i),
        .mc_o       (mc),
        .pc_o       (pc),
        .oper_o     (oper),
        .acc_o      (acc),
        .is_store_o (is_store)
    );

    dirxfer_bus u_bus (
        .mc_i       (mc),
        .tstate_i   (tstate),
        .is_store_i (is_store),
        .pc_i       (pc),
        .oper_i     (oper),
        .acc_i      (acc),
        .addr_o     (addr_o),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .mreq_n_o   (mreq_n_o),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o)
    );

    assign acc_o = acc;

    // R9: read and write strobes are mutually exclusive.
    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    // R9: a direction strobe is only active inside a memory request.
    p_strb_in_mreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> !mreq_n_o);

    // R2: a request that starts stays low for the following clock.
    p_mreq_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mreq_n_o) |=> !mreq_n_o);

    // R2: a request never lasts beyond two clocks.
    p_mreq_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n_o && $past(!mreq_n_o)) |=> mreq_n_o);

    // R8: a write strobe is always covered by the data output enable.
    p_wr_has_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> data_oe_o);

    // R8: the output enable is never on while reading.
    p_oe_not_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> rd_n_o);

endmodule

// File: tb/tb_dirxfer_seq.sv
`timescale 1ns/1ps
module tb_dirxfer_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data_i;
    logic [15:0] addr_o;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        mreq_n_o;
    logic        rd_n_o;
    logic        wr_n_o;
    logic [7:0]  acc_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dirxfer_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (data_i),
        .addr_o    (addr_o),
        .data_o    (data_o),
        .data_oe_o (data_oe_o),
        .mreq_n_o  (mreq_n_o),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o),
        .acc_o     (acc_o)
    );

    // Program in page 00h; a mapped input port at 4000h; elsewhere hi^lo.
    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (a[15:8] == 8'h00) begin
            case (a[7:0])
                8'h00: return 8'h3A;
                8'h01: return 8'h00;
                8'h02: return 8'h40;
                8'h03: return 8'h32;
                8'h04: return 8'h00;
                8'h05: return 8'h80;
                8'h06: return 8'h00;
                8'h07: return 8'h3A;
                8'h08: return 8'hCD;
                8'h09: return 8'hAB;
                8'h0A: return 8'h32;
                8'h0B: return 8'hFF;
                8'h0C: return 8'h7F;
                8'h0D: return 8'h3B;
                8'h0E: return 8'hFF;
                default: return 8'h00;
            endcase
        end else if (a == 16'h4000) begin
            return 8'h5A;
        end
        return a[15:8] ^ a[7:0];
    endfunction

    always_comb begin
        data_i = (!mreq_n_o && !rd_n_o) ? mem_rd(addr_o) : 8'hEE;
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One machine cycle; called with the first clock of the cycle showing.
    task automatic mcyc(input string req, input logic [15:0] a,
                        input bit is_wr, input logic [7:0] wdata);
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(req, "address", addr_o, a);
            chk("R8", "output enable", {15'd0, data_oe_o}, {15'd0, is_wr});
            if (k == 0) begin
                chk("R2", "mreq idle in first clock", {15'd0, mreq_n_o}, 16'd1);
                chk("R2", "rd idle in first clock",   {15'd0, rd_n_o},   16'd1);
                chk("R2", "wr idle in first clock",   {15'd0, wr_n_o},   16'd1);
            end else begin
                chk("R2", "mreq active", {15'd0, mreq_n_o}, 16'd0);
                chk("R9", "rd level",    {15'd0, rd_n_o},   {15'd0, is_wr});
                chk("R9", "wr level",    {15'd0, wr_n_o},   {15'd0, !is_wr});
                if (is_wr) chk("R5", "write data", {8'd0, data_o}, {8'd0, wdata});
            end
            @(negedge clk);
        end
    endtask

    task automatic chk_acc(input string req, input logic [7:0] exp);
        #1;
        chk(req, "accumulator", {8'd0, acc_o}, {8'd0, exp});
    endtask

    task automatic t_reset_r1();
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "reset address", addr_o, 16'h0000);
        chk("R1", "reset mreq", {15'd0, mreq_n_o}, 16'd1);
        chk("R1", "reset rd", {15'd0, rd_n_o}, 16'd1);
        chk("R1", "reset wr", {15'd0, wr_n_o}, 16'd1);
        chk("R1", "reset oe", {15'd0, data_oe_o}, 16'd0);
        chk("R1", "reset acc", {8'd0, acc_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_load_port_r6();
        mcyc("R1", 16'h0000, 1'b0, 8'h00);
        mcyc("R3", 16'h0001, 1'b0, 8'h00);
        mcyc("R3", 16'h0002, 1'b0, 8'h00);
        mcyc("R4", 16'h4000, 1'b0, 8'h00);
        chk_acc("R6", 8'h5A);
    endtask

    task automatic t_store_port_r5();
        mcyc("R3", 16'h0003, 1'b0, 8'h00);
        mcyc("R3", 16'h0004, 1'b0, 8'h00);
        mcyc("R3", 16'h0005, 1'b0, 8'h00);
        mcyc("R5", 16'h8000, 1'b1, 8'h5A);
        chk_acc("R5", 8'h5A);
    endtask

    task automatic t_nop_r7();
        mcyc("R7", 16'h0006, 1'b0, 8'h00);
        chk_acc("R7", 8'h5A);
    endtask

    task automatic t_load_endian_r4();
        mcyc("R7", 16'h0007, 1'b0, 8'h00);
        mcyc("R3", 16'h0008, 1'b0, 8'h00);
        mcyc("R3", 16'h0009, 1'b0, 8'h00);
        mcyc("R4", 16'hABCD, 1'b0, 8'h00);
        chk_acc("R6", 8'h66);
    endtask

    task automatic t_store_endian_r5();
        mcyc("R3", 16'h000A, 1'b0, 8'h00);
        mcyc("R3", 16'h000B, 1'b0, 8'h00);
        mcyc("R3", 16'h000C, 1'b0, 8'h00);
        mcyc("R4", 16'h7FFF, 1'b1, 8'h66);
    endtask

    task automatic t_unknown_op_r7();
        mcyc("R7", 16'h000D, 1'b0, 8'h00);
        chk_acc("R7", 8'h66);
        mcyc("R7", 16'h000E, 1'b0, 8'h00);
        mcyc("R7", 16'h000F, 1'b0, 8'h00);
        chk_acc("R7", 8'h66);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_r1();
        t_load_port_r6();
        t_store_port_r5();
        t_nop_r7();
        t_load_endian_r4();
        t_store_endian_r5();
        t_unknown_op_r7();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule